// File: doc/BRIEF.md
# Fixed-Latency Shared Memory Arbiter

This block is a small word-addressed store, built from lines of four 32-bit words, that several requesters share: instruction fetch, the data memory stage and the L1 cache. A requester raises its request line and holds its address and write data steady. It sees WAIT (its ok bit low) until the block has counted out a fixed access latency on its behalf. In the next cycle it sees OK (ok bit high) and the word is written at that clock edge.

Only one request is in service at any time. The latency count belongs to the requester that holds the grant. Waiting requesters are served strictly in order of first arrival, with no priority by identity. A separate side-door write port commits a word in the cycle it is presented. It ignores arbitration and latency, and it leaves the requester in service undisturbed. A combinational view port returns one whole line for inspection.

Top module: `shared_mem_arb`

## Requirements
- R1: After reset every word of every line reads as zero, and no ok bit is high.
- R2: Word address a selects word a mod 4 of line a div 4: its low two bits pick the word and the upper bits pick the line. Word k of a line appears on view bits [32k+31:32k].
- R3: With LATENCY = N, a requester granted from an idle block sees ok low for N consecutive cycles of held request. In cycle N+1 it sees ok high, and its word is written at the end of that cycle.
- R4: With LATENCY = 0, a request presented to an idle block gets ok high in its first cycle.
- R5: Storage does not change while a request is still receiving WAIT, unless a side-door write targets it.
- R6: At most one ok bit is high per cycle. A requester that arrives in a cycle where another gets OK sees WAIT, and its own latency count starts in the following cycle.
- R7: Waiting requesters are granted in order of first arrival, independent of requester index. Index 0 is fetch, 1 is the memory stage and 2 is the L1 cache.
- R8: Requesters that first assert in the same cycle are queued in ascending index: fetch, then memory stage, then L1 cache.
- R9: A side-door write raises side_ok_o in the same cycle and is visible on the view port after that clock edge. A requester partway through its latency still gets OK in its original cycle.
- R10: A requester that drops its request before OK is removed from the queue and writes nothing. If it held the grant, its count is discarded and the next requester starts counting from zero.
- R11: If a side-door write and a granted write hit the same word in the same cycle, the side-door data is stored.
- R12: The view port is combinational: a change of line index shows new data with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Request per requester (0 fetch, 1 memory stage, 2 L1 cache) |
| addr_i | input | NUM_REQ x ADDR_W | Word address per requester |
| wdata_i | input | NUM_REQ x WORD_W | Write data per requester |
| ok_o | output | NUM_REQ | OK per requester; low while a request waits |
| side_we_i | input | 1 | Side-door write strobe |
| side_addr_i | input | ADDR_W | Side-door word address |
| side_wdata_i | input | WORD_W | Side-door write data |
| side_ok_o | output | 1 | Side-door completion, same cycle |
| view_line_i | input | LINE_W | Line index for the view port |
| view_data_o | output | LINE_WORDS x WORD_W | All words of the selected line |

## Verification
The bench sweeps every word address from every requester alone, once with a latency of two and once with a latency of zero. These sweeps separate wrong address mapping, a miscounted latency and premature writes. Staggered arrivals, where the highest index comes before a lower one and a third request lands on another requester's OK cycle, separate true arrival order from fixed priority. They also show whether a count leaks into the following grant. Simultaneous arrivals expose the tie-break. A mid-wait drop shows whether a discarded count is reused. Side-door writes during a wait, and on the same word as a completing grant, show that the bypass neither stalls nor is overwritten.

// File: rtl/shared_mem_pkg.sv
package shared_mem_pkg;
  parameter int unsigned NUM_REQUESTERS = 3;

  typedef enum logic [1:0] {
    REQ_FETCH  = 2'd0,
    REQ_MEMSTG = 2'd1,
    REQ_L1     = 2'd2
  } req_id_e;
endpackage

// File: rtl/arb_fcfs.sv
module arb_fcfs #(
  parameter int unsigned NUM_REQ = 3,
  parameter int unsigned LATENCY = 2,
  localparam int unsigned ID_W   = $clog2(NUM_REQ),
  localparam int unsigned LEN_W  = $clog2(NUM_REQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] ok_o,
  output logic               fire_o,
  output logic [ID_W-1:0]    head_id_o
);
  localparam int unsigned CNT_W = (LATENCY > 0) ? $clog2(LATENCY + 1) : 1;

  logic [ID_W-1:0]    q_id_q [NUM_REQ];
  logic [ID_W-1:0]    q_n    [NUM_REQ];
  logic [LEN_W-1:0]   q_len_q, len_n;
  logic [NUM_REQ-1:0] in_q_q, in_q_n;
  logic [CNT_W-1:0]   cnt_q, cnt_eff;
  logic               gnt_vld_q;
  logic [ID_W-1:0]    gnt_id_q;

  logic [ID_W-1:0]    ord [NUM_REQ+1];
  logic [LEN_W-1:0]   len;
  logic               head_vld, fire;
  logic [ID_W-1:0]    head;

  // live order: surviving queue entries, then fresh arrivals by index
  always_comb begin
    for (int i = 0; i <= NUM_REQ; i++) ord[i] = '0;
    len = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (LEN_W'(i) < q_len_q && req_i[q_id_q[i]]) begin
        ord[len] = q_id_q[i];
        len      = len + 1'b1;
      end
    end
    for (int r = 0; r < NUM_REQ; r++) begin
      if (req_i[r] && !in_q_q[r]) begin
        ord[len] = ID_W'(r);
        len      = len + 1'b1;
      end
    end
  end

  assign head_vld = (len != '0);
  assign head     = ord[0];
  // count only survives if the same requester still heads the queue
  assign cnt_eff  = (gnt_vld_q && gnt_id_q == head) ? cnt_q : '0;
  assign fire     = head_vld && (cnt_eff == CNT_W'(LATENCY));

  always_comb begin
    ok_o = '0;
    if (fire) ok_o[head] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) q_n[i] = fire ? ord[i+1] : ord[i];
    len_n  = fire ? len - 1'b1 : len;
    in_q_n = '0;
    for (int i = 0; i < NUM_REQ; i++)
      if (LEN_W'(i) < len_n) in_q_n[q_n[i]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REQ; i++) q_id_q[i] <= '0;
      q_len_q   <= '0;
      in_q_q    <= '0;
      cnt_q     <= '0;
      gnt_vld_q <= 1'b0;
      gnt_id_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_REQ; i++) q_id_q[i] <= q_n[i];
      q_len_q <= len_n;
      in_q_q  <= in_q_n;
      if (fire || !head_vld) begin
        gnt_vld_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        gnt_vld_q <= 1'b1;
        gnt_id_q  <= head;
        cnt_q     <= cnt_eff + 1'b1;
      end
    end
  end

  assign fire_o    = fire;
  assign head_id_o = head;

  // R6
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ok_o));

  // R10
  q_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_len_q <= LEN_W'(NUM_REQ)) && ($countones(in_q_q) == int'(q_len_q)));

  generate
    if (LATENCY > 0) begin : g_lat_chk
      // R3
      wait_before_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok_o != '0) |-> (($past(req_i) & ok_o) == ok_o));
      // R6
      no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok_o != '0) |=> (ok_o == '0));
    end
  endgenerate
endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int unsigned NUM_LINES  = 4,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WORD_W     = 32,
  localparam int unsigned NUM_WORDS = NUM_LINES * LINE_WORDS,
  localparam int unsigned ADDR_W    = $clog2(NUM_WORDS),
  localparam int unsigned LINE_W    = $clog2(NUM_LINES),
  localparam int unsigned WSEL_W    = $clog2(LINE_WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            waddr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  input  logic                         side_we_i,
  input  logic [ADDR_W-1:0]            side_addr_i,
  input  logic [WORD_W-1:0]            side_wdata_i,
  input  logic [LINE_W-1:0]            view_line_i,
  output logic [LINE_WORDS*WORD_W-1:0] view_data_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
    end else begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      // side door is last so it wins a same-word collision
      if (side_we_i) mem_q[side_addr_i] <= side_wdata_i;
    end
  end

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_view
    assign view_data_o[k*WORD_W +: WORD_W] = mem_q[{view_line_i, WSEL_W'(k)}];
  end

  // R9
  side_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_we_i |=> (mem_q[$past(side_addr_i)] == $past(side_wdata_i)));

  // R11
  side_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && side_we_i && waddr_i == side_addr_i)
      |=> (mem_q[$past(side_addr_i)] == $past(side_wdata_i)));
endmodule

// File: rtl/shared_mem_arb.sv
module shared_mem_arb
  import shared_mem_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 4,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned NUM_REQ    = NUM_REQUESTERS,
  parameter int unsigned LATENCY    = 2,
  localparam int unsigned ADDR_W    = $clog2(NUM_LINES * LINE_WORDS),
  localparam int unsigned LINE_W    = $clog2(NUM_LINES),
  localparam int unsigned ID_W      = $clog2(NUM_REQ)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_REQ-1:0]                req_i,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0]    addr_i,
  input  logic [NUM_REQ-1:0][WORD_W-1:0]    wdata_i,
  output logic [NUM_REQ-1:0]                ok_o,
  input  logic                              side_we_i,
  input  logic [ADDR_W-1:0]                 side_addr_i,
  input  logic [WORD_W-1:0]                 side_wdata_i,
  output logic                              side_ok_o,
  input  logic [LINE_W-1:0]                 view_line_i,
  output logic [LINE_WORDS*WORD_W-1:0]      view_data_o
);
  logic            fire;
  logic [ID_W-1:0] head_id;

  arb_fcfs #(
    .NUM_REQ (NUM_REQ),
    .LATENCY (LATENCY)
  ) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ok_o      (ok_o),
    .fire_o    (fire),
    .head_id_o (head_id)
  );

  line_store #(
    .NUM_LINES  (NUM_LINES),
    .LINE_WORDS (LINE_WORDS),
    .WORD_W     (WORD_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (fire),
    .waddr_i      (addr_i[head_id]),
    .wdata_i      (wdata_i[head_id]),
    .side_we_i    (side_we_i),
    .side_addr_i  (side_addr_i),
    .side_wdata_i (side_wdata_i),
    .view_line_i  (view_line_i),
    .view_data_o  (view_data_o)
  );

  assign side_ok_o = side_we_i;

  // R5
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ok_o == '0) && !side_we_i)
      |=> ((view_data_o == $past(view_data_o)) || (view_line_i != $past(view_line_i))));
endmodule

// File: tb/shared_mem_arb_tb.sv
`timescale 1ns/1ps
module shared_mem_arb_tb_top;
  localparam int LAT = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [2:0]       req;
  logic [2:0][3:0]  addr;
  logic [2:0][31:0] wdata;
  logic [2:0]       ok, ok_z;
  logic             side_we;
  logic [3:0]       side_addr;
  logic [31:0]      side_wdata;
  logic             side_ok, side_ok_z;
  logic [1:0]       view_line;
  logic [127:0]     view_data, view_data_z;

  logic [31:0] exp_mem [16];
  logic [31:0] v;
  int          n_chk  = 0;
  int          n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  shared_mem_arb #(.LATENCY(LAT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .ok_o(ok), .side_we_i(side_we), .side_addr_i(side_addr), .side_wdata_i(side_wdata),
    .side_ok_o(side_ok), .view_line_i(view_line), .view_data_o(view_data));

  shared_mem_arb #(.LATENCY(0)) dut_z_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .ok_o(ok_z), .side_we_i(side_we), .side_addr_i(side_addr), .side_wdata_i(side_wdata),
    .side_ok_o(side_ok_z), .view_line_i(view_line), .view_data_o(view_data_z));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input logic [127:0] d, input int k);
    return d[k*32 +: 32];
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req = '0; addr = '0; wdata = '0;
    side_we = 1'b0; side_addr = '0; side_wdata = '0; view_line = '0;
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state, R12 view without clock
    #1;
    chk("R1 ok idle", 32'(ok), 32'd0);
    for (int l = 0; l < 4; l++) begin
      view_line = 2'(l);
      #0.2;
      for (int k = 0; k < 4; k++) chk("R1 R12 zero word", wd(view_data, k), 32'd0);
    end
    tick();

    // R2 R3 R4 R5 sweep: every requester, every address
    for (int r = 0; r < 3; r++) begin
      for (int a = 0; a < 16; a++) begin
        v = 32'hA500_0000 | 32'(r << 8) | 32'(a);
        req = 3'(1 << r); addr[r] = 4'(a); wdata[r] = v; view_line = 2'(a >> 2);
        for (int c = 0; c <= LAT; c++) begin
          #1;
          if (c == 0) chk("R4 zero-latency ok", 32'(ok_z), 32'(1 << r));
          if (c < LAT) begin
            chk("R3 wait", 32'(ok), 32'd0);
            chk("R5 hold while waiting", wd(view_data, a % 4), exp_mem[a]);
          end else begin
            chk("R3 ok after latency", 32'(ok), 32'(1 << r));
          end
          tick();
        end
        req = '0; exp_mem[a] = v;
        #1;
        for (int k = 0; k < 4; k++)
          chk("R2 word map", wd(view_data, k), exp_mem[(a / 4) * 4 + k]);
        chk("R4 zero-latency write", wd(view_data_z, a % 4), v);
        tick();
      end
    end

    // R6 R7 staggered arrivals: fetch, then L1, then mem stage on fetch's OK cycle
    addr[0] = 4'd0; wdata[0] = 32'hB000_0000;
    addr[2] = 4'd1; wdata[2] = 32'hB000_0002;
    addr[1] = 4'd2; wdata[1] = 32'hB000_0001;
    for (int c = 0; c <= 3 * LAT + 2; c++) begin
      req[0] = (c <= LAT);
      req[2] = (c >= 1) && (c <= 2 * LAT + 1);
      req[1] = (c >= LAT);
      #1;
      chk((c >= LAT && c <= 2 * LAT + 1) ? "R6 single grant" : "R7 arrival order",
          32'(ok), (c == LAT) ? 32'd1 : (c == 2 * LAT + 1) ? 32'd4 : (c == 3 * LAT + 2) ? 32'd2 : 32'd0);
      tick();
    end
    req = '0; view_line = 2'd0;
    exp_mem[0] = 32'hB000_0000; exp_mem[1] = 32'hB000_0002; exp_mem[2] = 32'hB000_0001;
    #1;
    for (int k = 0; k < 3; k++) chk("R7 data", wd(view_data, k), exp_mem[k]);
    tick();

    // R8 simultaneous arrival tie-break
    for (int r = 0; r < 3; r++) begin
      addr[r] = 4'(8 + r); wdata[r] = 32'hC000_0000 | 32'(r);
    end
    for (int c = 0; c <= 3 * LAT + 2; c++) begin
      req[0] = (c <= LAT);
      req[1] = (c <= 2 * LAT + 1);
      req[2] = 1'b1;
      #1;
      chk("R8 tie-break", 32'(ok),
          (c == LAT) ? 32'd1 : (c == 2 * LAT + 1) ? 32'd2 : (c == 3 * LAT + 2) ? 32'd4 : 32'd0);
      tick();
    end
    req = '0; view_line = 2'd2;
    for (int r = 0; r < 3; r++) exp_mem[8 + r] = 32'hC000_0000 | 32'(r);
    #1;
    for (int k = 0; k < 3; k++) chk("R8 data", wd(view_data, k), exp_mem[8 + k]);
    tick();

    // R9 side door during a wait
    addr[1] = 4'd5; wdata[1] = 32'hD000_0001; view_line = 2'd1;
    side_addr = 4'd6; side_wdata = 32'h5100_0006;
    for (int c = 0; c <= LAT; c++) begin
      req[1] = 1'b1;
      side_we = (c == 1);
      #1;
      if (c == 1) chk("R9 side ok same cycle", 32'(side_ok), 32'd1);
      if (c >= 2) chk("R9 side data visible", wd(view_data, 2), 32'h5100_0006);
      if (c < LAT) chk("R5 hold during side", wd(view_data, 1), exp_mem[5]);
      chk("R9 wait undisturbed", 32'(ok), (c == LAT) ? 32'd2 : 32'd0);
      tick();
    end
    req = '0; side_we = 1'b0;
    exp_mem[5] = 32'hD000_0001; exp_mem[6] = 32'h5100_0006;
    #1;
    chk("R9 granted data", wd(view_data, 1), exp_mem[5]);
    tick();

    // R11 side door collides with a completing grant
    addr[0] = 4'd7; wdata[0] = 32'hD000_0007;
    side_addr = 4'd7; side_wdata = 32'h5200_0007;
    for (int c = 0; c <= LAT; c++) begin
      req[0] = 1'b1;
      side_we = (c == LAT);
      #1;
      chk("R11 grant timing", 32'(ok), (c == LAT) ? 32'd1 : 32'd0);
      tick();
    end
    req = '0; side_we = 1'b0; exp_mem[7] = 32'h5200_0007;
    #1;
    chk("R11 side wins", wd(view_data, 3), exp_mem[7]);
    tick();

    // R10 granted requester drops mid-wait
    addr[0] = 4'd12; wdata[0] = 32'hE000_000C;
    addr[1] = 4'd13; wdata[1] = 32'hE000_000D;
    view_line = 2'd3;
    for (int c = 0; c <= LAT + 1; c++) begin
      req[0] = (c == 0);
      req[1] = 1'b1;
      #1;
      chk("R10 fresh count after drop", 32'(ok), (c == LAT + 1) ? 32'd2 : 32'd0);
      tick();
    end
    req = '0; exp_mem[13] = 32'hE000_000D;
    #1;
    chk("R10 dropped writes nothing", wd(view_data, 0), exp_mem[12]);
    chk("R10 survivor data", wd(view_data, 1), exp_mem[13]);
    tick();
    for (int c = 0; c <= LAT; c++) begin
      req[0] = 1'b1;
      #1;
      chk("R10 re-request full latency", 32'(ok), (c == LAT) ? 32'd1 : 32'd0);
      tick();
    end
    req = '0; exp_mem[12] = 32'hE000_000C;
    #1;
    chk("R10 re-request data", wd(view_data, 0), exp_mem[12]);
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule